// File: doc/BRIEF.md
# Console Character Port Register Block

This block gives a 16-bit processor four memory-mapped registers for a character console: an input status word, an input character word, an output status word and an output character word. The processor polls or takes interrupts by reading the status words. It takes a typed character by reading the input character word, and it sends a character by writing the output character word. On the keyboard side, characters arrive on a valid/ready stream. On the display side, characters leave on a valid/ready stream.

Each side holds at most one character. Once a character is waiting on the input side, the input stream is back-pressured: `kb_ready` stays low until software reads the character. While a character waits to go out, or while the display recovers, further writes to the output word are dropped. The read path is a combinational multiplexer. A read at one of the device addresses returns device data, and any other access passes the memory word through. Each side raises an interrupt request when its ready bit and its enable bit are both set.

Stream rules:
- A transfer happens on a rising edge where valid and ready are both high.
- Once `dp_valid` rises, it stays high and `dp_char` holds its value until the transfer happens.
- `kb_ready` low means the keyboard source must hold its character or drop it.

Top module: `con_io_regs`

## Requirements
- R1: A read (`bus_rd`=1) at 0xFE00, 0xFE02, 0xFE04 or 0xFE06 drives `rd_data` from the device register. Any other address drives `rd_data` from `mem_rdata`, in the same cycle.
- R2: A keyboard transfer stores the 8-bit code. From the next cycle, a read at 0xFE02 returns it in bits [7:0] with bits [15:8] zero, and a read at 0xFE00 shows bit 15 set.
- R3: While input status bit 15 is one, `kb_ready` is low and offered characters are not stored.
- R4: A read at 0xFE02 while input status bit 15 is one returns the stored character. It clears bit 15 from the next cycle, and `kb_ready` rises again.
- R5: A read at 0xFE02 while input status bit 15 is zero returns the last character and changes no state.
- R6: Output status bit 15 is one when the display can take a character. A write at 0xFE06 while it is one raises `dp_valid` with bits [7:0] on `dp_char` and clears bit 15, both from the next cycle.
- R7: A write at 0xFE06 while output status bit 15 is zero is ignored. `dp_char` keeps its value and no further transfer follows.
- R8: `dp_valid` and `dp_char` hold until `dp_ready`. After the accepting edge, `dp_valid` is low and bit 15 stays zero for one more cycle, then bit 15 returns to one.
- R9: A write at 0xFE00 or 0xFE04 changes only bit 14, the interrupt enable. Bit 15 is unaffected and bits [13:0] read zero.
- R10: `kb_irq` equals input bit 15 AND input bit 14, and `dp_irq` equals output bit 15 AND output bit 14.
- R11: After reset, input status reads 0x0000, output status reads 0x8000, `kb_ready` is 1, and `dp_valid`, `kb_irq` and `dp_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe; side effects on this edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| mem_rdata | input | 16 | Word from the memory array |
| rd_data | output | 16 | Word for the memory data register |
| kb_valid | input | 1 | Keyboard character offered |
| kb_char | input | 8 | Keyboard character code |
| kb_ready | output | 1 | Block can take a keyboard character |
| dp_valid | output | 1 | Character offered to display |
| dp_char | output | 8 | Display character code |
| dp_ready | input | 1 | Display takes the character |
| kb_irq | output | 1 | Keyboard interrupt request |
| dp_irq | output | 1 | Display interrupt request |

## Verification
`rd_data` is combinational. The bench drives each bus access on a falling edge and samples `rd_data` 1 ns later, before the edge that commits the access's side effects. Every state change (capture, clear, send, enable) becomes visible on the cycle after the rising edge that caused it, so the bench looks for it with the next access. Display recovery is checked on both edges after acceptance: one edge leaves bit 15 at zero, and the second edge sets it to one.

// File: rtl/con_io_pkg.sv
package con_io_pkg;
  localparam int WORD_W    = 16;
  localparam int CHAR_W    = 8;
  localparam int READY_BIT = 15;
  localparam int IE_BIT    = 14;

  typedef enum logic [1:0] {
    DSP_IDLE    = 2'd0,
    DSP_SEND    = 2'd1,
    DSP_RECOVER = 2'd2
  } dsp_state_t;
endpackage

// File: rtl/con_io_dec.sv
module con_io_dec #(
  parameter int          AW       = 16,
  parameter logic [15:0] KBS_ADDR = 16'hFE00,
  parameter logic [15:0] KBD_ADDR = 16'hFE02,
  parameter logic [15:0] DSS_ADDR = 16'hFE04,
  parameter logic [15:0] DSD_ADDR = 16'hFE06
) (
  input  logic [AW-1:0] addr,
  output logic          hit_kbs,
  output logic          hit_kbd,
  output logic          hit_dss,
  output logic          hit_dsd,
  output logic          hit_any
);
  always_comb begin
    hit_kbs = (addr == KBS_ADDR[AW-1:0]);
    hit_kbd = (addr == KBD_ADDR[AW-1:0]);
    hit_dss = (addr == DSS_ADDR[AW-1:0]);
    hit_dsd = (addr == DSD_ADDR[AW-1:0]);
    hit_any = hit_kbs | hit_kbd | hit_dss | hit_dsd;
  end
endmodule

// File: rtl/con_io_kbd.sv
module con_io_kbd #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kb_valid,
  input  logic [CW-1:0] kb_char,
  output logic          kb_ready,
  input  logic          rd_data_acc,
  input  logic          wr_stat,
  input  logic          ie_wdata,
  output logic          full,
  output logic          ie,
  output logic [CW-1:0] char_q
);
  assign kb_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      ie     <= 1'b0;
      char_q <= '0;
    end else begin
      if (kb_valid && kb_ready) begin
        char_q <= kb_char;
        full   <= 1'b1;
      end else if (rd_data_acc && full) begin
        full <= 1'b0;
      end
      if (wr_stat) ie <= ie_wdata;
    end
  end

  // R3: a waiting character is neither overwritten nor lost without a read
  a_r3_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_data_acc) |=> (full && $stable(char_q)));
  // R4: reading the pending character frees the slot
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rd_data_acc) |=> !full);
  // R5: a read with nothing pending leaves the stored code alone
  a_r5_empty_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && rd_data_acc && !kb_valid) |=> (!full && $stable(char_q)));
endmodule

// File: rtl/con_io_dsp.sv
module con_io_dsp
  import con_io_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic [CW-1:0] wdata_char,
  input  logic          wr_stat,
  input  logic          ie_wdata,
  output logic          dp_valid,
  output logic [CW-1:0] dp_char,
  input  logic          dp_ready,
  output logic          rdy,
  output logic          ie
);
  dsp_state_t state;

  assign rdy      = (state == DSP_IDLE);
  assign dp_valid = (state == DSP_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= DSP_IDLE;
      dp_char <= '0;
      ie      <= 1'b0;
    end else begin
      unique case (state)
        DSP_IDLE: if (wr_data) begin
          dp_char <= wdata_char;
          state   <= DSP_SEND;
        end
        DSP_SEND:    if (dp_ready) state <= DSP_RECOVER;
        DSP_RECOVER: state <= DSP_IDLE;
        default:     state <= DSP_IDLE;
      endcase
      if (wr_stat) ie <= ie_wdata;
    end
  end

  // R6: an accepted write starts a transfer and drops readiness
  a_r6_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && wr_data) |=> (dp_valid && !rdy));
  // R7: writes while busy do not disturb the outgoing code
  a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && wr_data) |=> $stable(dp_char));
  // R8: valid holds until the display takes it
  a_r8_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !dp_ready) |=> (dp_valid && $stable(dp_char)));
  // R8: one recovery cycle after acceptance, then ready again
  a_r8_recover_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && dp_ready) |=> (!dp_valid && !rdy));
  a_r8_recover_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_valid && !rdy) |=> rdy);
endmodule

// File: rtl/con_io_regs.sv
module con_io_regs
  import con_io_pkg::*;
#(
  parameter logic [15:0] KBS_ADDR = 16'hFE00,
  parameter logic [15:0] KBD_ADDR = 16'hFE02,
  parameter logic [15:0] DSS_ADDR = 16'hFE04,
  parameter logic [15:0] DSD_ADDR = 16'hFE06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] rd_data,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_char,
  output logic              kb_ready,
  output logic              dp_valid,
  output logic [CHAR_W-1:0] dp_char,
  input  logic              dp_ready,
  output logic              kb_irq,
  output logic              dp_irq
);
  localparam int PAD_W = WORD_W - CHAR_W;

  logic hit_kbs, hit_kbd, hit_dss, hit_dsd, hit_any;
  logic kb_full, kb_ie, dp_rdy, dp_ie;
  logic [CHAR_W-1:0] kb_q;

  con_io_dec #(
    .AW(WORD_W), .KBS_ADDR(KBS_ADDR), .KBD_ADDR(KBD_ADDR),
    .DSS_ADDR(DSS_ADDR), .DSD_ADDR(DSD_ADDR)
  ) u_dec (
    .addr(bus_addr), .hit_kbs(hit_kbs), .hit_kbd(hit_kbd),
    .hit_dss(hit_dss), .hit_dsd(hit_dsd), .hit_any(hit_any)
  );

  con_io_kbd #(.CW(CHAR_W)) u_kbd (
    .clk(clk), .rst_n(rst_n),
    .kb_valid(kb_valid), .kb_char(kb_char), .kb_ready(kb_ready),
    .rd_data_acc(bus_rd && hit_kbd),
    .wr_stat(bus_wr && hit_kbs), .ie_wdata(bus_wdata[IE_BIT]),
    .full(kb_full), .ie(kb_ie), .char_q(kb_q)
  );

  con_io_dsp #(.CW(CHAR_W)) u_dsp (
    .clk(clk), .rst_n(rst_n),
    .wr_data(bus_wr && hit_dsd), .wdata_char(bus_wdata[CHAR_W-1:0]),
    .wr_stat(bus_wr && hit_dss), .ie_wdata(bus_wdata[IE_BIT]),
    .dp_valid(dp_valid), .dp_char(dp_char), .dp_ready(dp_ready),
    .rdy(dp_rdy), .ie(dp_ie)
  );

  assign kb_irq = kb_full & kb_ie;
  assign dp_irq = dp_rdy & dp_ie;

  always_comb begin
    rd_data = mem_rdata;
    if (bus_rd && hit_any) begin
      rd_data = '0;
      if (hit_kbs) begin
        rd_data[READY_BIT] = kb_full;
        rd_data[IE_BIT]    = kb_ie;
      end
      if (hit_dss) begin
        rd_data[READY_BIT] = dp_rdy;
        rd_data[IE_BIT]    = dp_ie;
      end
      if (hit_kbd) rd_data = {{PAD_W{1'b0}}, kb_q};
      if (hit_dsd) rd_data = {{PAD_W{1'b0}}, dp_char};
    end
  end

  // R1: a read outside the device window passes memory through
  a_r1_mem_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[15:8] != 8'hFE) |-> (rd_data == mem_rdata));
  // R2: a keyboard transfer sets the input ready flag for the next cycle
  a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && kb_ready) |=> (!kb_ready && kb_q == $past(kb_char)));
  // R9: a status write never touches the ready flags
  a_r9_stat_wr_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_dss && dp_valid) |=> !dp_rdy);
endmodule

// File: tb/test_con_io_regs.sv
module test_con_io_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, mem_rdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] rd_data;
  logic kb_valid = 1'b0;
  logic [7:0] kb_char = '0;
  logic kb_ready, dp_valid, dp_ready = 1'b0, kb_irq, dp_irq;
  logic [7:0] dp_char;

  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  con_io_regs i_con_io_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mem_rdata(mem_rdata),
    .rd_data(rd_data), .kb_valid(kb_valid), .kb_char(kb_char),
    .kb_ready(kb_ready), .dp_valid(dp_valid), .dp_char(dp_char),
    .dp_ready(dp_ready), .kb_irq(kb_irq), .dp_irq(dp_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = rd_data;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic kb_send(input logic [7:0] c);
    @(negedge clk);
    kb_valid = 1'b1; kb_char = c;
    @(posedge clk); #1 kb_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(16'hFE00, d); chk("R11 kbd status", d, 16'h0000);
    rd(16'hFE04, d); chk("R11 dsp status", d, 16'h8000);
    chk("R11 outputs", {12'b0, kb_ready, dp_valid, kb_irq, dp_irq}, 16'h0008);
  endtask

  task automatic t_decode;
    logic [15:0] d;
    mem_rdata = 16'h1234;
    rd(16'h3000, d); chk("R1 mem 3000", d, 16'h1234);
    rd(16'hFE08, d); chk("R1 mem FE08", d, 16'h1234);
    mem_rdata = 16'hBEEF;
    rd(16'hFE01, d); chk("R1 mem FE01", d, 16'hBEEF);
    rd(16'hFE04, d); chk("R1 device FE04", d, 16'h8000);
  endtask

  task automatic t_kbd;
    logic [15:0] d;
    kb_send(8'h41);
    rd(16'hFE00, d); chk("R2 ready set", d, 16'h8000);
    chk("R3 kb_ready low", {15'b0, kb_ready}, 16'h0000);
    kb_send(8'h42);
    rd(16'hFE02, d); chk("R3/R2 first char kept", d, 16'h0041);
    rd(16'hFE00, d); chk("R4 ready cleared", d, 16'h0000);
    chk("R4 kb_ready high", {15'b0, kb_ready}, 16'h0001);
    rd(16'hFE02, d); chk("R5 empty read data", d, 16'h0041);
    rd(16'hFE00, d); chk("R5 empty read status", d, 16'h0000);
    kb_send(8'hFF);
    rd(16'hFE02, d); chk("R2 high code", d, 16'h00FF);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    wr(16'hFE00, 16'hFFFF);
    rd(16'hFE00, d); chk("R9 kbd only bit14", d, 16'h4000);
    chk("R10 kb_irq idle", {15'b0, kb_irq}, 16'h0000);
    kb_send(8'h33);
    chk("R10 kb_irq pending", {15'b0, kb_irq}, 16'h0001);
    wr(16'hFE02, 16'h0000);
    rd(16'hFE02, d); chk("R10 kbd data", d, 16'h0033);
    chk("R10 kb_irq cleared", {15'b0, kb_irq}, 16'h0000);
    wr(16'hFE04, 16'h7FFF);
    rd(16'hFE04, d); chk("R9 dsp bits", d, 16'hC000);
    chk("R10 dp_irq", {15'b0, dp_irq}, 16'h0001);
    wr(16'hFE00, 16'h0000);
    rd(16'hFE00, d); chk("R9 kbd ie off", d, 16'h0000);
  endtask

  task automatic t_disp;
    logic [15:0] d;
    dp_ready = 1'b0;
    wr(16'hFE06, 16'h1263);
    #1 chk("R6 valid and char", {7'b0, dp_valid, dp_char}, 16'h0163);
    rd(16'hFE04, d); chk("R6 ready cleared", d, 16'h4000);
    chk("R10 dp_irq busy", {15'b0, dp_irq}, 16'h0000);
    wr(16'hFE04, 16'h0000);
    wr(16'hFE06, 16'h0077);
    #1 chk("R7 char kept", {7'b0, dp_valid, dp_char}, 16'h0163);
    rd(16'hFE04, d); chk("R9 status write kept busy", d, 16'h0000);
    @(negedge clk); dp_ready = 1'b1;
    @(posedge clk); #1 dp_ready = 1'b0;
    chk("R8 valid dropped", {15'b0, dp_valid}, 16'h0000);
    rd(16'hFE04, d); chk("R8 recovery cycle", d, 16'h0000);
    rd(16'hFE04, d); chk("R8 ready again", d, 16'h8000);
    chk("R7 no second send", {7'b0, dp_valid, dp_char}, 16'h0063);
    rd(16'hFE06, d); chk("R1 dsp data read", d, 16'h0063);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nvec++; nbad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_decode();
    t_kbd();
    t_irq();
    t_disp();
    finish_run();
  end
endmodule